// File: doc/BRIEF.md
# Direction-Selectable Self-Synchronizing Line Scrambler

This block sits between the framer and the symbol mapper of a two-bits-per-symbol subscriber line transceiver. It holds two 23-stage shift registers. One scrambles the outgoing bit stream. The other descrambles the incoming bit stream. Each bit is an exclusive-OR of the data bit with two delayed taps of its own register. The descrambler feeds on the received scrambled bits, so it falls into step with the far-end scrambler within 23 bits from any starting state, with no alignment exchange.

The two line directions use different feedback polynomials. Traffic from the exchange end toward the subscriber end uses 1 + x^-5 + x^-23. Traffic in the other direction uses 1 + x^-18 + x^-23. A single end-select input tells the block which end it sits at, and that choice assigns one polynomial to each direction. During sync-word symbols the framer raises a per-direction bypass. The bit then passes through unchanged and that direction's register keeps its contents. Each direction advances by one bit on each cycle where its enable is high.

Top module: `dual_dir_scrambler`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears both shift registers and drives both output bits to 0 after that edge.
- R2: On an enabled, non-bypassed transmit cycle, `tx_scr` after the edge equals `tx_bit ^ h[t] ^ h[23]`. Here h[k] is the transmit output k enabled non-bypassed cycles earlier, and t is the short tap of the transmit polynomial. From reset with `end_sel`=0, an input of a single 1 followed by 0s gives output 1 on steps 0, 5 and 10 of the first twelve steps.
- R3: The scrambler shifts its own output bit into h[1], so the next enabled step sees that bit at tap 1.
- R4: On an enabled, non-bypassed receive cycle, `rx_dscr` after the edge equals `rx_bit ^ g[t'] ^ g[23]`. Here g[k] is the received input bit k such cycles earlier, so the scrambled bit, not the result, is what gets shifted in.
- R5: With `end_sel`=0 (exchange end), transmit uses short tap 5 and receive uses short tap 18. With `end_sel`=1 (subscriber end), transmit uses tap 18 and receive uses tap 5.
- R6: When a direction's bypass is high on an enabled cycle, its output after the edge equals its input bit and its shift register keeps its value.
- R7: When a direction's enable is low, its output bit and shift register hold their values.
- R8: A descrambler with the matching polynomial, starting from arbitrary contents, reproduces the far scrambler's input exactly once it has taken in 23 scrambled bits.
- R9: An exchange-end transmit path looped into a subscriber-end receive path reproduces the transmitted data bit for bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| end_sel | input | 1 | 0: exchange end, 1: subscriber end |
| tx_en | input | 1 | Transmit bit enable |
| tx_bypass | input | 1 | Transmit sync-word bypass |
| tx_bit | input | 1 | Transmit data bit before scrambling |
| tx_scr | output | 1 | Registered scrambled transmit bit |
| rx_en | input | 1 | Receive bit enable |
| rx_bypass | input | 1 | Receive sync-word bypass |
| rx_bit | input | 1 | Received scrambled bit |
| rx_dscr | output | 1 | Registered descrambled receive bit |

## Verification
Each output is registered, so a direction's result appears right after the rising edge where that direction's enable was sampled high. The bench sets the inputs at a falling edge and reads the outputs at the next falling edge, exactly one register stage later. In the loopback arrangement the far receiver sees the near transmitter's registered output one edge later, so its descrambled bit lags the data bit by two edges. The bench compares it against the data it drove one tick earlier. Comparison starts only after the 23-bit settling window has passed.

// File: rtl/scr_pkg.sv
package scr_pkg;

    localparam int unsigned STAGES    = 23;
    localparam int unsigned TAP_DOWN  = 5;
    localparam int unsigned TAP_UP    = 18;

    typedef enum logic {
        END_EXCHANGE   = 1'b0,
        END_SUBSCRIBER = 1'b1
    } end_kind_e;

    typedef enum logic {
        ROLE_SCRAMBLE   = 1'b0,
        ROLE_DESCRAMBLE = 1'b1
    } role_e;

    typedef struct packed {
        logic bypass;
        logic data;
    } bit_slot_t;

    function automatic logic tap_fold(input logic d, input logic a, input logic b);
        return d ^ a ^ b;
    endfunction

endpackage

// File: rtl/scr_tap_plan.sv
module scr_tap_plan
    import scr_pkg::*;
(
    input  end_kind_e kind,
    output logic      tx_use_up,
    output logic      rx_use_up
);
    always_comb begin
        tx_use_up = (kind == END_SUBSCRIBER);
        rx_use_up = (kind == END_EXCHANGE);
    end
endmodule

// File: rtl/scr_shift_unit.sv
module scr_shift_unit
    import scr_pkg::*;
#(
    parameter role_e       ROLE   = ROLE_SCRAMBLE,
    parameter int unsigned DEPTH  = STAGES,
    parameter int unsigned TAP_A  = TAP_DOWN,
    parameter int unsigned TAP_B  = TAP_UP
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      sel_b,
    input  bit_slot_t slot_in,
    output logic      out_bit
);
    logic [DEPTH:1] hist_q;
    logic           out_q;
    logic           short_tap;
    logic           mixed;
    logic           push;

    always_comb begin
        short_tap = sel_b ? hist_q[TAP_B] : hist_q[TAP_A];
        mixed     = tap_fold(slot_in.data, short_tap, hist_q[DEPTH]);
    end

    generate
        if (ROLE == ROLE_SCRAMBLE) begin : g_scr
            assign push = mixed;
            // The scrambler feeds back what it sent
            assert_feed_output_R3: assert property (@(posedge clk) disable iff (rst)
                (en && !slot_in.bypass) |=> (hist_q[1] == out_q));
        end else begin : g_dscr
            assign push = slot_in.data;
            // The descrambler feeds back what it received
            assert_feed_input_R4: assert property (@(posedge clk) disable iff (rst)
                (en && !slot_in.bypass) |=> (hist_q[1] == $past(slot_in.data)));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
            out_q  <= 1'b0;
        end else if (en) begin
            if (slot_in.bypass) begin
                out_q <= slot_in.data;
            end else begin
                out_q  <= mixed;
                hist_q <= {hist_q[DEPTH-1:1], push};
            end
        end
    end

    assign out_bit = out_q;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (hist_q == '0 && out_q == 1'b0));

    assert_bypass_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (en && slot_in.bypass) |=> (hist_q == $past(hist_q) && out_q == $past(slot_in.data)));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(hist_q) && $stable(out_q)));

endmodule

// File: rtl/dual_dir_scrambler.sv
module dual_dir_scrambler
    import scr_pkg::*;
#(
    parameter int unsigned DEPTH    = STAGES,
    parameter int unsigned SHORT_DN = TAP_DOWN,
    parameter int unsigned SHORT_UP = TAP_UP
) (
    input  logic clk,
    input  logic rst,
    input  logic end_sel,
    input  logic tx_en,
    input  logic tx_bypass,
    input  logic tx_bit,
    output logic tx_scr,
    input  logic rx_en,
    input  logic rx_bypass,
    input  logic rx_bit,
    output logic rx_dscr
);
    end_kind_e kind;
    logic      tx_use_up;
    logic      rx_use_up;
    bit_slot_t tx_slot;
    bit_slot_t rx_slot;

    assign kind    = end_kind_e'(end_sel);
    assign tx_slot = '{bypass: tx_bypass, data: tx_bit};
    assign rx_slot = '{bypass: rx_bypass, data: rx_bit};

    scr_tap_plan u_plan (
        .kind      (kind),
        .tx_use_up (tx_use_up),
        .rx_use_up (rx_use_up)
    );

    scr_shift_unit #(
        .ROLE  (ROLE_SCRAMBLE),
        .DEPTH (DEPTH),
        .TAP_A (SHORT_DN),
        .TAP_B (SHORT_UP)
    ) u_tx (
        .clk     (clk),
        .rst     (rst),
        .en      (tx_en),
        .sel_b   (tx_use_up),
        .slot_in (tx_slot),
        .out_bit (tx_scr)
    );

    scr_shift_unit #(
        .ROLE  (ROLE_DESCRAMBLE),
        .DEPTH (DEPTH),
        .TAP_A (SHORT_DN),
        .TAP_B (SHORT_UP)
    ) u_rx (
        .clk     (clk),
        .rst     (rst),
        .en      (rx_en),
        .sel_b   (rx_use_up),
        .slot_in (rx_slot),
        .out_bit (rx_dscr)
    );

    // R5: the two directions never share a polynomial
    assert_dirs_differ_R5: assert property (@(posedge clk) disable iff (rst)
        (tx_use_up != rx_use_up));

endmodule

// File: tb/test_dual_dir_scrambler.sv
module test_dual_dir_scrambler;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst = 1'b1;
    logic end_sel = 1'b0;
    logic tx_en = 1'b0, tx_byp = 1'b0, tx_bit = 1'b0;
    logic rx_en = 1'b0, rx_byp = 1'b0, rx_bit = 1'b0;
    logic tx_scr, rx_dscr;

    logic f_rx_en = 1'b0, f_lb = 1'b0, junk = 1'b0;
    logic f_rx_bit, f_tx_scr, f_rx_dscr;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    logic [23:1] mt = '0, mr = '0;
    logic e_tx = 1'b0, e_rx = 1'b0;
    logic sent [0:127];

    // Impulse response from reset at the exchange end: {data in, expected out}
    localparam logic [1:0] IMPULSE [12] = '{
        2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b01,
        2'b00, 2'b00, 2'b00, 2'b00, 2'b01, 2'b00
    };

    dual_dir_scrambler i_dual_dir_scrambler (
        .clk(clk), .rst(rst), .end_sel(end_sel),
        .tx_en(tx_en), .tx_bypass(tx_byp), .tx_bit(tx_bit), .tx_scr(tx_scr),
        .rx_en(rx_en), .rx_bypass(rx_byp), .rx_bit(rx_bit), .rx_dscr(rx_dscr)
    );

    assign f_rx_bit = f_lb ? tx_scr : junk;

    dual_dir_scrambler i_far (
        .clk(clk), .rst(rst), .end_sel(1'b1),
        .tx_en(1'b0), .tx_bypass(1'b0), .tx_bit(1'b0), .tx_scr(f_tx_scr),
        .rx_en(f_rx_en), .rx_bypass(1'b0), .rx_bit(f_rx_bit), .rx_dscr(f_rx_dscr)
    );

    task automatic chk(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tx_en = 1'b0; rx_en = 1'b0; f_rx_en = 1'b0;
        tick(); tick();
        rst = 1'b0;
        mt = '0; mr = '0; e_tx = 1'b0; e_rx = 1'b0;
        chk("R1 tx after reset", tx_scr, 1'b0);
        chk("R1 rx after reset", rx_dscr, 1'b0);
    endtask

    // One cycle on the main instance, with model update and checks
    task automatic cyc(input logic ten, input logic tb, input logic td,
                       input logic ren, input logic rb, input logic rd,
                       input string ttag, input string rtag);
        int ttap = end_sel ? 18 : 5;
        int rtap = end_sel ? 5 : 18;
        logic v;
        tx_en = ten; tx_byp = tb; tx_bit = td;
        rx_en = ren; rx_byp = rb; rx_bit = rd;
        if (ten) begin
            if (tb) e_tx = td;
            else begin
                v = td ^ mt[ttap] ^ mt[23];
                e_tx = v;
                mt = {mt[22:1], v};
            end
        end
        if (ren) begin
            if (rb) e_rx = rd;
            else begin
                e_rx = rd ^ mr[rtap] ^ mr[23];
                mr = {mr[22:1], rd};
            end
        end
        tick();
        chk(ttag, tx_scr, e_tx);
        chk(rtag, rx_dscr, e_rx);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R2: table walk, impulse at the exchange end
        end_sel = 1'b0;
        for (int i = 0; i < 12; i++) begin
            cyc(1'b1, 1'b0, IMPULSE[i][1], 1'b0, 1'b0, 1'b0, "R2 model", "R7 rx idle");
            chk("R2 table", tx_scr, IMPULSE[i][0]);
        end

        // R3 / R4: random traffic at the exchange end
        for (int i = 0; i < 60; i++)
            cyc(1'b1, 1'b0, 1'($urandom), 1'b1, 1'b0, 1'($urandom), "R3 tx", "R4 rx");

        // R5: subscriber end swaps the polynomials
        do_reset();
        end_sel = 1'b1;
        for (int i = 0; i < 24; i++)
            cyc(1'b1, 1'b0, (i == 0), 1'b1, 1'b0, (i == 0), "R5 tx impulse", "R5 rx impulse");
        for (int i = 0; i < 60; i++)
            cyc(1'b1, 1'b0, 1'($urandom), 1'b1, 1'b0, 1'($urandom), "R5 tx", "R5 rx");

        // R6: bypass bursts with unbypassed traffic between them
        for (int i = 0; i < 60; i++) begin
            logic b = ((i % 10) < 3);
            cyc(1'b1, b, 1'($urandom), 1'b1, b, 1'($urandom), "R6 tx", "R6 rx");
        end

        // R7: enable gaps
        for (int i = 0; i < 40; i++) begin
            logic te = (i % 3) != 0;
            logic re = (i % 4) != 1;
            cyc(te, 1'b0, 1'($urandom), re, 1'b0, 1'($urandom), "R7 tx", "R7 rx");
        end

        // R1: reset in mid-stream
        do_reset();
        end_sel = 1'b0;

        // R9: loopback from reset, exchange transmit into subscriber receive
        rx_en = 1'b0;
        f_lb = 1'b1; f_rx_en = 1'b1; tx_en = 1'b1; tx_byp = 1'b0;
        for (int j = 0; j < 80; j++) begin
            tx_bit = 1'($urandom);
            sent[j] = tx_bit;
            tick();
            if (j >= 24) chk("R9 loopback", f_rx_dscr, sent[j-1]);
        end

        // R8: load junk into the far receiver, then reconnect
        f_lb = 1'b0;
        for (int j = 0; j < 40; j++) begin
            junk = 1'($urandom);
            tx_bit = 1'($urandom);
            tick();
        end
        f_lb = 1'b1;
        for (int j = 0; j < 70; j++) begin
            tx_bit = 1'($urandom);
            sent[j] = tx_bit;
            tick();
            if (j >= 24) chk("R8 self-sync", f_rx_dscr, sent[j-1]);
        end
        tx_en = 1'b0; f_rx_en = 1'b0;

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule